// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block keeps an asynchronous page-mode DRAM alive. After reset it waits out the power-up pause and then issues a short burst of wake-up refresh cycles. Until that burst has finished, the `ready` output stays low so that the access controller stays off the bus. During normal running a slot timer marks when each refresh is due. At each slot the block raises `ref_req`, waits for `grant`, and then drives a complete refresh cycle on the strobes itself. The default is the CAS-before-RAS style, in which the device's internal counter picks the row. A row-addressed style, with no CAS and an internal row counter driven onto `addr`, can be selected with `rowonly_mode`. Setting `ext_period` doubles the slot interval, for parts that allow a relaxed refresh period.

While `grant` is withheld, missed slots are counted up to `MAX_OWED`. When the grant returns they are paid back in one back-to-back burst. If even more slots go by, the refresh window counts as lost: `ready` drops, and the wake-up burst is repeated before normal access resumes.

A power manager asks for self refresh with `sr_req`. The block then takes the bus, performs a CAS-before-RAS entry and holds both strobes low. It keeps them low for at least `T_RASS` cycles and for as long as the request stays high. On exit it holds all strobes high for `T_RPS` cycles. In row-addressed style it then refreshes every row once before it releases the bus. In CAS-before-RAS style no catch-up is needed.

FSM states:
- `S_PWRUP`: power-up pause.
- `S_IDLE`: bus released.
- `S_SETUP`: CAS lead in CBR style, or address setup in row style.
- `S_ACT`: RAS low.
- `S_PRE`: precharge.
- `S_SELF`: self refresh held.
- `S_SREXIT`: exit precharge.

Transitions:
- PWRUP→IDLE when the pause ends.
- IDLE→SETUP on `grant`, to start a wake, owed or self-entry burst.
- SETUP→ACT, or SETUP→SELF when the burst is a self entry.
- ACT→PRE.
- PRE→SETUP while the burst has cycles left, otherwise PRE→IDLE.
- SELF→SREXIT once the minimum time has passed and the request has dropped.
- SREXIT→SETUP for the row catch-up, or SREXIT→IDLE.

Top module: `dram_refresh_mgr`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `ready` and `sr_ack` are 0.
- R2: `ref_req` stays 0 for the first `PWRUP_WAIT` clock edges after reset and is 1 after edge `PWRUP_WAIT`. Exactly `WAKE_CYCLES` RAS falling edges occur before `ready` first becomes 1.
- R3: In CAS-before-RAS style, every falling edge of `ras_n` finds `cas_n` already 0 in the previous cycle and `we_n` at 1.
- R4: `ras_n` or `cas_n` is 0 only while `grant` is 1.
- R5: With `grant` held at 1, consecutive refresh cycles start `INTERVAL` clocks apart, or `2*INTERVAL` clocks apart when `ext_period` is 1.
- R6: When k slots (1 ≤ k ≤ `MAX_OWED`) pass while `grant` is 0, no refresh cycle occurs during that time. After `grant` returns, exactly k refresh cycles run back-to-back, each starting `T_CSR+T_RAS+T_RP` clocks after the previous one, before `ref_req` drops.
- R7: When more than `MAX_OWED` slots pass unserved, `ready` goes to 0. On the next grant, `WAKE_CYCLES` refresh cycles run before `ready` returns to 1.
- R8: On `sr_req` while ready, the block performs a CAS-before-RAS entry (in either style) and then holds `ras_n` and `cas_n` at 0 with `sr_ack` at 1.
- R9: `ras_n` stays 0 in self refresh for exactly `T_RASS` cycles if `sr_req` drops early. If `sr_req` is held longer, it stays 0 until one cycle after `sr_req` drops.
- R10: After self-refresh exit, the strobes stay at 1 with `ref_req` at 1 for exactly `T_RPS` cycles. In CAS-before-RAS style, `ref_req` then drops with no catch-up refresh.
- R11: In row-addressed style (`rowonly_mode`=1), refresh cycles keep `cas_n` at 1. The `addr` value at each RAS fall is the previous value plus one, modulo `ROWS`, starting from 0 after reset.
- R12: In row-addressed style, exactly `ROWS` refresh cycles follow self-refresh exit before `ref_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rowonly_mode | input | 1 | 1 = row-addressed refresh, 0 = CAS-before-RAS |
| ext_period | input | 1 | 1 = doubled refresh interval |
| sr_req | input | 1 | Self-refresh request from power manager |
| grant | input | 1 | Bus granted to this block |
| ref_req | output | 1 | Bus request; held for the whole owned sequence |
| ready | output | 1 | Device awake; normal access allowed |
| sr_ack | output | 1 | Self refresh in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | $clog2(ROWS) | Row address in row-addressed style, else 0 |

## Verification
A wrong slot count or owed count shows up at once as a RAS fall at the wrong clock, or as one cycle too many or too few in a payback burst. The bench therefore measures fall-to-fall spacing and counts falls between a grant edge and the drop of `ref_req`. A wrong state in the self-refresh path appears within tens of cycles as a RAS low time or precharge time that is one off, or as an unexpected catch-up burst. A row counter that skips or repeats is caught at the next RAS fall by comparing `addr` with its expected successor.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef enum logic [2:0] {
        S_PWRUP,
        S_IDLE,
        S_SETUP,
        S_ACT,
        S_PRE,
        S_SELF,
        S_SREXIT
    } rfm_state_e;

    function automatic int rfm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfm_slot_timer.sv
module rfm_slot_timer #(
    parameter int INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext,
    output logic tick
);
    localparam int CW = $clog2(2 * INTERVAL + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = ext ? CW'(2 * INTERVAL) : CW'(INTERVAL);
    assign tick  = run && (cnt_q >= limit - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R5: the count is reset by the cycle after each tick
    a_r5_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/rfm_owed_ctr.sv
module rfm_owed_ctr #(
    parameter int MAX_OWED = 8,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          take,
    output logic [OW-1:0] owed,
    output logic          lapse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed  <= '0;
            lapse <= 1'b0;
        end else if (take) begin
            owed  <= tick ? OW'(1) : '0;
            lapse <= 1'b0;
        end else if (tick) begin
            if (owed == OW'(MAX_OWED)) begin
                lapse <= 1'b1;
            end else begin
                owed <= owed + OW'(1);
            end
        end
    end

    // R6: the debt never exceeds its cap
    a_r6_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(MAX_OWED));

    // R7: a lost window is only flagged once the debt is full
    a_r7_lapse_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lapse) |-> ($past(owed) == OW'(MAX_OWED)));

endmodule

// File: rtl/rfm_row_ctr.sv
module rfm_row_ctr #(
    parameter int ROWS = 8192,
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [RW-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
        end
    end

    // R11: the row pointer only moves by one or wraps to zero
    a_r11_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step) |-> ((row == $past(row) + RW'(1)) || (row == '0)));

endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr
    import rfm_pkg::*;
#(
    parameter int INTERVAL    = 1562,
    parameter int PWRUP_WAIT  = 10000,
    parameter int WAKE_CYCLES = 8,
    parameter int T_CSR       = 1,
    parameter int T_RAS       = 5,
    parameter int T_RP        = 3,
    parameter int T_RASS      = 10000,
    parameter int T_RPS       = 11,
    parameter int MAX_OWED    = 8,
    parameter int ROWS        = 8192,
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rowonly_mode,
    input  logic          ext_period,
    input  logic          sr_req,
    input  logic          grant,
    output logic          ref_req,
    output logic          ready,
    output logic          sr_ack,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic [RW-1:0] addr
);
    localparam int TMAX = rfm_max(rfm_max(rfm_max(PWRUP_WAIT, T_RASS), rfm_max(T_RPS, T_CSR)),
                                  rfm_max(T_RAS, T_RP));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BMAX = rfm_max(rfm_max(ROWS, WAKE_CYCLES), MAX_OWED);
    localparam int BW   = $clog2(BMAX + 1);
    localparam int OW   = $clog2(MAX_OWED + 1);

    rfm_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [BW-1:0] burst_q, burst_d;
    logic          self_mode_q, self_mode_d;
    logic          waking_q, waking_d;
    logic          awake_q, awake_d;
    logic          wake_pend_q, wake_pend_d;
    logic          catchup_q, catchup_d;

    logic          tick, take, run, row_step, row_cycle, pending;
    logic [OW-1:0] owed;
    logic          lapse;
    logic [RW-1:0] row;

    assign run = awake_q && !self_mode_q && !self_mode_d && !catchup_q;

    rfm_slot_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .ext(ext_period), .tick(tick)
    );

    rfm_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .owed(owed), .lapse(lapse)
    );

    rfm_row_ctr #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .step(row_step), .row(row)
    );

    assign row_cycle = rowonly_mode && !self_mode_q;
    assign pending   = wake_pend_q || lapse || (owed != '0) || (sr_req && awake_q);

    // next-state logic
    always_comb begin
        state_d     = state_q;
        tmr_d       = tmr_q;
        burst_d     = burst_q;
        self_mode_d = self_mode_q;
        waking_d    = waking_q;
        awake_d     = awake_q;
        wake_pend_d = wake_pend_q;
        catchup_d   = catchup_q;
        take        = 1'b0;
        row_step    = 1'b0;
        unique case (state_q)
            S_PWRUP: begin
                if (tmr_q == '0) state_d = S_IDLE;
                else             tmr_d   = tmr_q - TW'(1);
            end
            S_IDLE: begin
                if (grant) begin
                    if (wake_pend_q || lapse) begin
                        burst_d     = BW'(WAKE_CYCLES);
                        take        = 1'b1;
                        wake_pend_d = 1'b0;
                        awake_d     = 1'b0;
                        waking_d    = 1'b1;
                        state_d     = S_SETUP;
                        tmr_d       = TW'(T_CSR - 1);
                    end else if (owed != '0) begin
                        burst_d = BW'(owed);
                        take    = 1'b1;
                        state_d = S_SETUP;
                        tmr_d   = TW'(T_CSR - 1);
                    end else if (sr_req && awake_q) begin
                        burst_d     = BW'(1);
                        self_mode_d = 1'b1;
                        state_d     = S_SETUP;
                        tmr_d       = TW'(T_CSR - 1);
                    end
                end
            end
            S_SETUP: begin
                if (tmr_q != '0) begin
                    tmr_d = tmr_q - TW'(1);
                end else if (self_mode_q) begin
                    state_d = S_SELF;
                    tmr_d   = TW'(T_RASS - 1);
                end else begin
                    state_d = S_ACT;
                    tmr_d   = TW'(T_RAS - 1);
                end
            end
            S_ACT: begin
                if (tmr_q != '0) begin
                    tmr_d = tmr_q - TW'(1);
                end else begin
                    state_d = S_PRE;
                    tmr_d   = TW'(T_RP - 1);
                end
            end
            S_PRE: begin
                if (tmr_q != '0) begin
                    tmr_d = tmr_q - TW'(1);
                end else begin
                    row_step = row_cycle;
                    if (burst_q > BW'(1)) begin
                        burst_d = burst_q - BW'(1);
                        state_d = S_SETUP;
                        tmr_d   = TW'(T_CSR - 1);
                    end else begin
                        burst_d   = '0;
                        state_d   = S_IDLE;
                        catchup_d = 1'b0;
                        if (waking_q) begin
                            waking_d = 1'b0;
                            awake_d  = 1'b1;
                        end
                    end
                end
            end
            S_SELF: begin
                if (tmr_q != '0) begin
                    tmr_d = tmr_q - TW'(1);
                end else if (!sr_req) begin
                    state_d = S_SREXIT;
                    tmr_d   = TW'(T_RPS - 1);
                end
            end
            S_SREXIT: begin
                if (tmr_q != '0) begin
                    tmr_d = tmr_q - TW'(1);
                end else begin
                    self_mode_d = 1'b0;
                    if (rowonly_mode) begin
                        burst_d   = BW'(ROWS);
                        catchup_d = 1'b1;
                        state_d   = S_SETUP;
                        tmr_d     = TW'(T_CSR - 1);
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_PWRUP;
            tmr_q       <= TW'(PWRUP_WAIT - 1);
            burst_q     <= '0;
            self_mode_q <= 1'b0;
            waking_q    <= 1'b0;
            awake_q     <= 1'b0;
            wake_pend_q <= 1'b1;
            catchup_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            tmr_q       <= tmr_d;
            burst_q     <= burst_d;
            self_mode_q <= self_mode_d;
            waking_q    <= waking_d;
            awake_q     <= awake_d;
            wake_pend_q <= wake_pend_d;
            catchup_q   <= catchup_d;
        end
    end

    // output decode
    always_comb begin
        ref_req = 1'b0;
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        addr    = '0;
        unique case (state_q)
            S_PWRUP:  ref_req = 1'b0;
            S_IDLE:   ref_req = pending;
            S_SETUP: begin
                ref_req = 1'b1;
                cas_n   = row_cycle;
                addr    = row_cycle ? row : '0;
            end
            S_ACT: begin
                ref_req = 1'b1;
                ras_n   = 1'b0;
                cas_n   = row_cycle;
                addr    = row_cycle ? row : '0;
            end
            S_PRE:    ref_req = 1'b1;
            S_SELF: begin
                ref_req = 1'b1;
                ras_n   = 1'b0;
                cas_n   = 1'b0;
            end
            S_SREXIT: ref_req = 1'b1;
            default:  ref_req = 1'b0;
        endcase
    end

    assign we_n   = 1'b1;
    assign ready  = awake_q && !lapse;
    assign sr_ack = (state_q == S_SELF);

    // ---------------- checking counters and assertions ----------------
    logic [TW:0]   self_cycles;
    logic [BW-1:0] wake_falls;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            self_cycles <= '0;
            wake_falls  <= '0;
        end else begin
            if (state_q == S_SETUP)
                self_cycles <= '0;
            else if (state_q == S_SELF && self_cycles != '1)
                self_cycles <= self_cycles + 1'b1;
            if (!waking_q)
                wake_falls <= '0;
            else if (state_q == S_SETUP && state_d == S_ACT)
                wake_falls <= wake_falls + BW'(1);
        end
    end

    // R4: strobes only active while the bus is granted
    a_r4_strobes_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> grant);

    // R3: a RAS fall with CAS low must have had CAS low one cycle earlier
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R11: row-style address holds from setup into the RAS fall
    a_r11_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |-> $stable(addr));

    // R9: self refresh lasts at least the minimum RAS time
    a_r9_self_min: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SREXIT && $past(state_q) == S_SELF) |-> (self_cycles >= (TW+1)'(T_RASS)));

    // R2: ready only comes back after the full wake-up burst
    a_r2_wake_complete: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (wake_falls == BW'(WAKE_CYCLES)));

endmodule

// File: tb/tb_dram_refresh_mgr.sv
module tb_dram_refresh_mgr;
    localparam int CLK_P = 10;
    localparam int IV    = 20;
    localparam int PW    = 30;
    localparam int WK    = 8;
    localparam int TCSR  = 1;
    localparam int TRAS  = 3;
    localparam int TRP   = 2;
    localparam int TRASS = 10;
    localparam int TRPS  = 4;
    localparam int MOWED = 3;
    localparam int NROWS = 16;
    localparam int AW    = $clog2(NROWS);
    localparam int CYC   = TCSR + TRAS + TRP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rowonly_mode = 1'b0, ext_period = 1'b0, sr_req = 1'b0, grant = 1'b0;
    logic ref_req, ready, sr_ack, ras_n, cas_n, we_n;
    logic [AW-1:0] addr;

    int tests = 0, fails = 0, cyc = 0, wd = 0;
    int falls = 0, rowfalls = 0, last_t = 0, prev_t = 0, seq_err = 0, prev_addr = 0;
    logic have_prev = 1'b0, ras_prev = 1'b1, cas_prev = 1'b1, fall_cas_prev = 1'b1, fall_we = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    dram_refresh_mgr #(.INTERVAL(IV), .PWRUP_WAIT(PW), .WAKE_CYCLES(WK), .T_CSR(TCSR),
        .T_RAS(TRAS), .T_RP(TRP), .T_RASS(TRASS), .T_RPS(TRPS), .MAX_OWED(MOWED),
        .ROWS(NROWS)) dut (
        .clk(clk), .rst_n(rst_n), .rowonly_mode(rowonly_mode), .ext_period(ext_period),
        .sr_req(sr_req), .grant(grant), .ref_req(ref_req), .ready(ready), .sr_ack(sr_ack),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr));

    // monitor of strobe activity
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            have_prev = 1'b0; rowfalls = 0; seq_err = 0;
        end else if (ras_prev && !ras_n) begin
            falls++; prev_t = last_t; last_t = cyc;
            fall_cas_prev = cas_prev; fall_we = we_n;
            if (cas_n) begin
                rowfalls++;
                if (have_prev && (int'(addr) != (prev_addr + 1) % NROWS)) seq_err++;
                if (!have_prev && addr != '0) seq_err++;
                prev_addr = int'(addr); have_prev = 1'b1;
            end
        end
        ras_prev = ras_n; cas_prev = cas_n;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wait_fall();
        int n = falls;
        for (int i = 0; i < 2000 && falls == n; i++) step();
    endtask

    task automatic wait_req_low();
        for (int i = 0; i < 2000 && ref_req; i++) step();
    endtask

    task automatic do_reset(input logic rowmode);
        rst_n = 1'b0; grant = 1'b1; sr_req = 1'b0; ext_period = 1'b0; rowonly_mode = rowmode;
        repeat (3) step();
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        chk(!ref_req && !ready && !sr_ack, "R1 flags in reset", {ref_req, ready, sr_ack}, 0);
    endtask

    task automatic t_powerup();
        int f0;
        f0 = falls;
        rst_n = 1'b1;
        repeat (PW - 1) step();
        chk(!ref_req, "R2 request held during pause", ref_req, 0);
        step();
        chk(ref_req, "R2 request after pause", ref_req, 1);
        for (int i = 0; i < 500 && !ready; i++) step();
        chk(falls - f0 == WK, "R2 wake-up cycles before ready", falls - f0, WK);
    endtask

    task automatic t_pacing();
        wait_fall(); wait_fall();
        chk(last_t - prev_t == IV, "R5 normal spacing", last_t - prev_t, IV);
        chk(!fall_cas_prev && fall_we, "R3 CAS leads RAS, WE high", fall_cas_prev, 0);
        ext_period = 1'b1;
        wait_fall(); wait_fall();
        chk(last_t - prev_t == 2 * IV, "R5 extended spacing", last_t - prev_t, 2 * IV);
        ext_period = 1'b0;
        wait_fall(); wait_fall();
        chk(last_t - prev_t == IV, "R5 spacing restored", last_t - prev_t, IV);
    endtask

    task automatic t_missed();
        int f0, f1;
        wait_fall(); wait_req_low();
        grant = 1'b0; f0 = falls;
        repeat (35) step();
        chk(falls == f0, "R6 no cycle while grant withheld", falls - f0, 0);
        chk(ref_req, "R6 request raised while owed", ref_req, 1);
        grant = 1'b1; f1 = falls;
        step();
        wait_req_low();
        chk(falls - f1 == 2, "R6 owed cycles paid back", falls - f1, 2);
        chk(last_t - prev_t == CYC, "R6 back-to-back spacing", last_t - prev_t, CYC);
    endtask

    task automatic t_lapse();
        int f0;
        wait_fall(); wait_req_low();
        chk(ready, "R7 ready before lapse", ready, 1);
        grant = 1'b0;
        repeat (100) step();
        chk(!ready, "R7 ready dropped on lost window", ready, 0);
        grant = 1'b1; f0 = falls;
        for (int i = 0; i < 500 && !ready; i++) step();
        chk(falls - f0 == WK, "R7 wake-up repeated", falls - f0, WK);
    endtask

    task automatic t_self_cbr();
        int n, f0;
        wait_fall(); wait_req_low();
        sr_req = 1'b1;
        for (int i = 0; i < 50 && !sr_ack; i++) step();
        chk(sr_ack && !ras_n && !cas_n, "R8 self refresh held", {sr_ack, ras_n, cas_n}, 4);
        chk(!fall_cas_prev, "R8 entry is CAS before RAS", fall_cas_prev, 0);
        sr_req = 1'b0;
        n = 0;
        for (int i = 0; i < 500 && !ras_n; i++) begin n++; step(); end
        chk(n == TRASS, "R9 minimum self time", n, TRASS);
        n = 0;
        for (int i = 0; i < 500 && ref_req; i++) begin
            if (!ras_n || !cas_n) n = n + 1000;
            n++; step();
        end
        chk(n == TRPS, "R10 exit precharge length", n, TRPS);
        f0 = falls;
        repeat (10) step();
        chk(falls == f0, "R10 no catch-up in CBR style", falls - f0, 0);
        // long request
        sr_req = 1'b1;
        for (int i = 0; i < 50 && !sr_ack; i++) step();
        repeat (2 * TRASS) step();
        chk(!ras_n && sr_ack, "R9 held while request stays", ras_n, 0);
        sr_req = 1'b0;
        step();
        chk(ras_n, "R9 released after request drops", ras_n, 1);
        wait_req_low();
    endtask

    task automatic t_rowonly();
        int f0;
        do_reset(1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < 500 && !ready; i++) step();
        wait_fall(); wait_fall(); wait_fall();
        chk(rowfalls == falls - (falls - rowfalls) && rowfalls >= WK + 3, "R11 row cycles keep CAS high",
            rowfalls, WK + 3);
        chk(seq_err == 0, "R11 address sequence", seq_err, 0);
        wait_req_low();
        sr_req = 1'b1;
        for (int i = 0; i < 50 && !sr_ack; i++) step();
        chk(sr_ack && !cas_n, "R8 CBR entry in row style", cas_n, 0);
        sr_req = 1'b0;
        for (int i = 0; i < 500 && sr_ack; i++) step();
        f0 = rowfalls;
        wait_req_low();
        chk(rowfalls - f0 == NROWS, "R12 catch-up covers all rows", rowfalls - f0, NROWS);
        chk(seq_err == 0, "R11 address wraps in sequence", seq_err, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_pacing();
        t_missed();
        t_lapse();
        t_self_cbr();
        t_rowonly();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule